// File: doc/BRIEF.md
# Windowed Min/Max Watchdog Monitor

This block supervises a processor's liveness strobe. It requires the falling edges of that strobe to land inside a timing window. Each accepted edge opens a new window. An edge that comes before the window opens is an early (fast) fault. A window that closes with no edge at all is a late (slow) fault. Either fault produces one active-low fault pulse of fixed length. A two-bit code shows which kind of fault happened last.

The strobe input is asynchronous. It passes through a synchronizer chain, and a falling edge counts only if the strobe had been high for a minimum number of ticks before it. Short glitches are therefore rejected. While the system reset flag is active, or while a fault pulse is running, strobe edges are ignored and the window counter is held at zero. The first accepted edge after such a blanking period is exempt from the early check. A 3-bit select picks one of eight window pairs. All times are expressed as multiples of a tick unit set by parameter (UNIT_TICKS ticks per 0.1 ms).

Top module: `wwdg_monitor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `fault_n` is 1 and `fault_kind` is 2'b00.
- R2: An accepted falling edge is acted on 3 ticks after `kick_in` falls. If it arrives while the count of ticks since the window opened is below LO, `fault_n` goes low and `fault_kind` becomes 2'b01 (fast).
- R3: An accepted edge with a count of at least LO and at most HI produces no fault. It clears the count and opens a new window.
- R4: If the count reaches HI with no edge, `fault_n` goes low on the following tick and `fault_kind` becomes 2'b10 (slow). The count starts from the last accepted edge, or from the tick after blanking ends.
- R5: The fault pulse holds `fault_n` low for exactly PULSE_UNITS*UNIT_TICKS ticks and then releases it, unless `sys_rst_act` cuts the pulse short.
- R6: The first accepted edge after a fault pulse or after `sys_rst_act` ends is never treated as fast.
- R7: Falling edges of `kick_in` during a fault pulse are ignored. They neither fault nor use up the exemption of R6.
- R8: While `sys_rst_act` is high, `fault_n` is 1 from the next tick on, any running pulse is cancelled, kicks are ignored and the count stays at zero.
- R9: A falling edge counts only if the synchronized strobe was high for at least MIN_HIGH ticks just before it. A shorter high level is ignored.
- R10: `fault_kind` holds its value until the next fault and is never 2'b11.
- R11: `win_sel` sets LO/HI in units of 0.1 ms: 0:15/150, 1:150/1500, 2:150/4500, 3:15/150, 4:150/900, 5:230/630, 6:390/1080, 7:7190/18000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous block reset, active high |
| kick_in | input | 1 | Asynchronous liveness strobe from the processor |
| sys_rst_act | input | 1 | System reset active; blanks monitoring and the fault output |
| win_sel | input | 3 | Window option select |
| fault_n | output | 1 | Active-low fault pulse |
| fault_kind | output | 2 | Last fault type: 00 none, 01 fast, 10 slow |

## Verification
A strobe fall reaches the decision register three ticks after it is driven: two synchronizer stages and the edge register. The bench samples the fault result exactly three falling clock edges after driving the kick. A slow fault shows on the tick after the count reaches HI, which is HI+1 ticks after blanking is released. The bench checks `fault_n` high at HI and low at HI+1. Pulse length is measured by counting low samples from the first low one. The window table's boundary gaps (LO, LO+1, HI+1, HI+2 ticks between kicks) follow from the same three-tick offset applied to both edges.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;

   typedef enum logic [1:0] {
      FK_NONE = 2'b00,
      FK_FAST = 2'b01,
      FK_SLOW = 2'b10
   } fault_kind_e;

   localparam int unsigned MAX_HI_UNITS = 18000;

   // Lower window edge per option, in 0.1 ms units
   function automatic int unsigned lo_units(input logic [2:0] sel);
      case (sel)
         3'd0:    return 15;
         3'd1:    return 150;
         3'd2:    return 150;
         3'd3:    return 15;
         3'd4:    return 150;
         3'd5:    return 230;
         3'd6:    return 390;
         default: return 7190;
      endcase
   endfunction

   // Upper window edge per option, in 0.1 ms units
   function automatic int unsigned hi_units(input logic [2:0] sel);
      case (sel)
         3'd0:    return 150;
         3'd1:    return 1500;
         3'd2:    return 4500;
         3'd3:    return 150;
         3'd4:    return 900;
         3'd5:    return 630;
         3'd6:    return 1080;
         default: return MAX_HI_UNITS;
      endcase
   endfunction

endpackage

// File: rtl/wwdg_kick_filter.sv
module wwdg_kick_filter #(
   parameter int STAGES   = 2,
   parameter int MIN_HIGH = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic kick_async,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              cur;
   logic              prev;

   assign cur = chain[STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain[0] <= kick_async;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         prev <= cur;
      end
   end

   generate
      if (MIN_HIGH > 0) begin : g_filt
         localparam int HW = $clog2(MIN_HIGH + 1);
         logic [HW-1:0] hi_cnt;
         always_ff @(posedge clk) begin
            if (rst || !cur)                 hi_cnt <= '0;
            else if (hi_cnt != HW'(MIN_HIGH)) hi_cnt <= hi_cnt + 1'b1;
         end
         assign fall = prev & ~cur & (hi_cnt == HW'(MIN_HIGH));
      end else begin : g_raw
         assign fall = prev & ~cur;
      end
   endgenerate
endmodule

// File: rtl/wwdg_window.sv
module wwdg_window
   import wwdg_pkg::*;
#(
   parameter int UNIT_TICKS = 2,
   parameter int CNT_W      = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [2:0] win_sel,
   input  logic       fall,
   input  logic       blank,
   output logic       fast_hit,
   output logic       slow_hit
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lo_lim;
   logic [CNT_W-1:0] hi_lim;
   logic             exempt;

   assign lo_lim = CNT_W'(lo_units(win_sel) * UNIT_TICKS);
   assign hi_lim = CNT_W'(hi_units(win_sel) * UNIT_TICKS);

   always_comb begin
      fast_hit = !blank && fall && !exempt && (cnt < lo_lim);
      slow_hit = !blank && !fall && (cnt >= hi_lim);
   end

   always_ff @(posedge clk) begin
      if (rst || blank) begin
         cnt    <= '0;
         exempt <= 1'b1;
      end else if (fall) begin
         cnt    <= '0;
         exempt <= 1'b0;
      end else if (cnt < hi_lim) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/wwdg_pulse.sv
module wwdg_pulse
   import wwdg_pkg::*;
#(
   parameter int PULSE_TICKS = 20
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        sys_rst_act,
   input  logic        fast_hit,
   input  logic        slow_hit,
   output logic        active,
   output logic        fault_n,
   output fault_kind_e kind
);
   localparam int PW = $clog2(PULSE_TICKS + 1);

   logic [PW-1:0] pcnt;

   assign active  = (pcnt != '0);
   assign fault_n = !active;

   always_ff @(posedge clk) begin
      if (rst) begin
         pcnt <= '0;
         kind <= FK_NONE;
      end else if (sys_rst_act) begin
         pcnt <= '0;
      end else if (active) begin
         pcnt <= pcnt - 1'b1;
      end else if (fast_hit || slow_hit) begin
         pcnt <= PW'(PULSE_TICKS);
         kind <= fast_hit ? FK_FAST : FK_SLOW;
      end
   end
endmodule

// File: rtl/wwdg_monitor.sv
module wwdg_monitor
   import wwdg_pkg::*;
#(
   parameter int UNIT_TICKS  = 2,
   parameter int PULSE_UNITS = 10,
   parameter int MIN_HIGH    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       kick_in,
   input  logic       sys_rst_act,
   input  logic [2:0] win_sel,
   output logic       fault_n,
   output logic [1:0] fault_kind
);
   localparam int PULSE_TICKS = PULSE_UNITS * UNIT_TICKS;
   localparam int CNT_W       = $clog2(MAX_HI_UNITS * UNIT_TICKS + 1);
   localparam int MIN_LO      = 15 * UNIT_TICKS;

   initial begin
      assert (UNIT_TICKS > 0)  else $error("UNIT_TICKS must be positive");
      assert (PULSE_UNITS > 0) else $error("PULSE_UNITS must be positive");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (MIN_HIGH >= 0 && MIN_HIGH < MIN_LO)
         else $error("MIN_HIGH must be below the shortest lower limit");
   end

   logic        fall;
   logic        fast_hit;
   logic        slow_hit;
   logic        pulse_on;
   logic        blank;
   fault_kind_e kind;

   assign blank      = sys_rst_act | pulse_on;
   assign fault_kind = kind;

   wwdg_kick_filter #(
      .STAGES   (SYNC_STAGES),
      .MIN_HIGH (MIN_HIGH)
   ) u_filter (
      .clk        (clk),
      .rst        (rst),
      .kick_async (kick_in),
      .fall       (fall)
   );

   wwdg_window #(
      .UNIT_TICKS (UNIT_TICKS),
      .CNT_W      (CNT_W)
   ) u_window (
      .clk      (clk),
      .rst      (rst),
      .win_sel  (win_sel),
      .fall     (fall),
      .blank    (blank),
      .fast_hit (fast_hit),
      .slow_hit (slow_hit)
   );

   wwdg_pulse #(
      .PULSE_TICKS (PULSE_TICKS)
   ) u_pulse (
      .clk         (clk),
      .rst         (rst),
      .sys_rst_act (sys_rst_act),
      .fast_hit    (fast_hit),
      .slow_hit    (slow_hit),
      .active      (pulse_on),
      .fault_n     (fault_n),
      .kind        (kind)
   );
endmodule

// File: rtl/wwdg_monitor_chk.sv
module wwdg_monitor_chk #(
   parameter int PULSE_TICKS = 20
) (
   input logic       clk,
   input logic       rst,
   input logic       sys_rst_act,
   input logic       fault_n,
   input logic [1:0] fault_kind
);
   int unsigned low_run;

   always_ff @(posedge clk) begin
      if (rst || fault_n) low_run <= 0;
      else                low_run <= low_run + 1;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk) rst |=> (fault_n && fault_kind == 2'b00));

   // R5
   pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
      !fault_n |-> (low_run < PULSE_TICKS));

   // R5
   pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(fault_n) && !$past(sys_rst_act)) |-> (low_run == PULSE_TICKS));

   // R8
   sys_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      sys_rst_act |=> fault_n);

   // R10
   kind_code_chk: assert property (@(posedge clk) disable iff (rst)
      fault_kind != 2'b11);

   // R10
   kind_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$fell(fault_n) |-> $stable(fault_kind));

   // R2
   kind_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(fault_n) |-> (fault_kind != 2'b00));
endmodule

bind wwdg_monitor wwdg_monitor_chk #(
   .PULSE_TICKS (PULSE_TICKS)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .sys_rst_act (sys_rst_act),
   .fault_n     (fault_n),
   .fault_kind  (fault_kind)
);

// File: tb/wwdg_monitor_bench.sv
module wwdg_monitor_bench;
   localparam int UNIT  = 2;
   localparam int PULSE = 10 * UNIT;
   localparam int MINH  = 4;
   localparam int NVEC  = 30;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       kick_in = 1'b1;
   logic       sys_rst_act = 1'b0;
   logic [2:0] win_sel = 3'd0;
   logic       fault_n;
   logic [1:0] fault_kind;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   wwdg_monitor #(
      .UNIT_TICKS  (UNIT),
      .PULSE_UNITS (10),
      .MIN_HIGH    (MINH),
      .SYNC_STAGES (2)
   ) u_wwdg_monitor (
      .clk         (clk),
      .rst         (rst),
      .kick_in     (kick_in),
      .sys_rst_act (sys_rst_act),
      .win_sel     (win_sel),
      .fault_n     (fault_n),
      .fault_kind  (fault_kind)
   );

   // {sel, gap code, expected kind}; gap code 0:LO 1:LO+1 2:HI+1 3:HI+2
   localparam logic [6:0] VEC [NVEC] = '{
      {3'd0,2'd0,2'd1}, {3'd0,2'd1,2'd0}, {3'd0,2'd2,2'd0}, {3'd0,2'd3,2'd2},
      {3'd1,2'd0,2'd1}, {3'd1,2'd1,2'd0}, {3'd1,2'd2,2'd0}, {3'd1,2'd3,2'd2},
      {3'd2,2'd0,2'd1}, {3'd2,2'd1,2'd0}, {3'd2,2'd2,2'd0}, {3'd2,2'd3,2'd2},
      {3'd3,2'd0,2'd1}, {3'd3,2'd1,2'd0}, {3'd3,2'd2,2'd0}, {3'd3,2'd3,2'd2},
      {3'd4,2'd0,2'd1}, {3'd4,2'd1,2'd0}, {3'd4,2'd2,2'd0}, {3'd4,2'd3,2'd2},
      {3'd5,2'd0,2'd1}, {3'd5,2'd1,2'd0}, {3'd5,2'd2,2'd0}, {3'd5,2'd3,2'd2},
      {3'd6,2'd0,2'd1}, {3'd6,2'd1,2'd0}, {3'd6,2'd2,2'd0}, {3'd6,2'd3,2'd2},
      {3'd7,2'd0,2'd1}, {3'd7,2'd1,2'd0}
   };

   function automatic int lo_ticks(input int sel);
      int t [8] = '{15, 150, 150, 15, 150, 230, 390, 7190};
      return t[sel] * UNIT;
   endfunction

   function automatic int hi_ticks(input int sel);
      int t [8] = '{150, 1500, 4500, 150, 900, 630, 1080, 18000};
      return t[sel] * UNIT;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic [2:0] sel);
      @(negedge clk);
      rst = 1'b1; kick_in = 1'b1; sys_rst_act = 1'b0; win_sel = sel;
      tick(3);
      rst = 1'b0;
      tick(MINH + 2);
   endtask

   task automatic run_vec(input int sel, input int code, input int exp);
      int gap;
      case (code)
         0:       gap = lo_ticks(sel);
         1:       gap = lo_ticks(sel) + 1;
         2:       gap = hi_ticks(sel) + 1;
         default: gap = hi_ticks(sel) + 2;
      endcase
      do_reset(3'(sel));
      kick_in = 1'b0;             // first edge: exempt
      tick(2);
      kick_in = 1'b1;
      tick(gap - 2);
      kick_in = 1'b0;             // second edge, gap ticks later
      tick(3);
      // R2 R3 R4 R11
      check(fault_n == (exp == 0), $sformatf("R11 sel%0d code%0d fault_n", sel, code),
            int'(fault_n), int'(exp == 0));
      check(fault_kind == 2'(exp), $sformatf("R11 sel%0d code%0d kind", sel, code),
            int'(fault_kind), exp);
   endtask

   initial begin
      #2_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int cnt;
      bit seen_low;

      // R1 reset state
      do_reset(3'd0);
      check(fault_n == 1'b1, "R1 fault_n", int'(fault_n), 1);
      check(fault_kind == 2'b00, "R1 kind", int'(fault_kind), 0);

      // table walk: R2 R3 R4 R11
      for (int v = 0; v < NVEC; v++)
         run_vec(int'(VEC[v][6:4]), int'(VEC[v][3:2]), int'(VEC[v][1:0]));

      // R5 R6 R7 R10: pulse width, blanking and exemption after a fault
      do_reset(3'd0);
      kick_in = 1'b0; tick(2); kick_in = 1'b1; tick(8);
      kick_in = 1'b0; tick(2); kick_in = 1'b1; tick(1);
      check(fault_n == 1'b0, "R2 fast start", int'(fault_n), 0);
      check(fault_kind == 2'b01, "R2 fast kind", int'(fault_kind), 1);
      cnt = 0;
      while (!fault_n && cnt < 100) begin
         cnt++;
         if (cnt == 8) kick_in = 1'b0;  // R7 edge inside the pulse
         tick(1);
      end
      check(cnt == PULSE, "R5 pulse length", cnt, PULSE);
      check(fault_kind == 2'b01, "R10 kind held", int'(fault_kind), 1);
      kick_in = 1'b1; tick(6);
      kick_in = 1'b0; tick(3);
      check(fault_n == 1'b1, "R6 R7 exempt after pulse", int'(fault_n), 1);
      kick_in = 1'b1; tick(6);
      kick_in = 1'b0; tick(3);
      check(fault_n == 1'b0, "R6 exemption used", int'(fault_n), 0);
      tick(PULSE + 2);

      // R8 system reset blanking, then R4 slow timing from release
      do_reset(3'd0);
      sys_rst_act = 1'b1;
      seen_low = 1'b0;
      for (int i = 0; i < 3 * hi_ticks(0); i++) begin
         kick_in = ((i % 40) < 20);
         tick(1);
         if (!fault_n) seen_low = 1'b1;
      end
      kick_in = 1'b1;
      tick(MINH + 2);
      check(seen_low == 1'b0, "R8 quiet under sys reset", int'(seen_low), 0);
      sys_rst_act = 1'b0;
      tick(hi_ticks(0));
      check(fault_n == 1'b1, "R4 slow not yet", int'(fault_n), 1);
      tick(1);
      check(fault_n == 1'b0, "R4 slow edge", int'(fault_n), 0);
      check(fault_kind == 2'b10, "R4 slow kind", int'(fault_kind), 2);
      tick(3);
      sys_rst_act = 1'b1;
      tick(1);
      check(fault_n == 1'b1, "R8 pulse cancelled", int'(fault_n), 1);
      sys_rst_act = 1'b0;
      tick(2);
      check(fault_kind == 2'b10, "R10 kind after cancel", int'(fault_kind), 2);

      // R9 glitch rejection
      do_reset(3'd0);
      kick_in = 1'b0; tick(3);
      kick_in = 1'b1; tick(2);
      kick_in = 1'b0; tick(4);
      check(fault_n == 1'b1, "R9 short high ignored", int'(fault_n), 1);
      kick_in = 1'b1; tick(MINH);
      kick_in = 1'b0; tick(3);
      check(fault_n == 1'b0, "R9 full high accepted", int'(fault_n), 0);
      check(fault_kind == 2'b01, "R9 kind", int'(fault_kind), 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule